// File: doc/BRIEF.md
# RDS Block Hand-off Buffer

This block sits after an RDS block detector and hands decoded 16-bit blocks to a host. For each received block the detector gives a one-cycle strobe, an offset type (A, B, C, C' or D), the data word and a good/bad flag. The block tracks whether the block stream is in step, keeps the newest accepted block and the one before it in two host-visible registers, and drives a data-available flag (with an active-low copy), an overflow flag, a sync bit and an interrupt.

The host reads through a read-select port. The data output shows the selected register at all times. Asserting the read enable marks an access: this access clears the flags that belong to the register being read. A mode input selects the fast PI-search mode. In that mode, while the stream is not yet in step, only blocks that carry the PI code (A and C') are handed over. Block timing comes only from the strobes. Host read latency is counted in clock cycles relative to those strobes.

Top module: `rds_blkbuf`

## Requirements
- R1: After reset, dav=0, dav_n=1, ovf=0, sync=0, irq=0, and the last and previous registers are 0.
- R2: Offset codes are A=0, B=1, C=2, C'=3 and D=4. Codes 5 to 7 count as bad blocks. sync becomes 1 when two good blocks arrive one after the other and the second is the successor of the first in the cycle A→B→(C or C')→D→A. Any bad block in between breaks the pair.
- R3: The event that sets sync also sets irq on the next cycle. Once sync is 1 it stays 1 until reset.
- R4: When fast_pi=1 and sync=0 (the value before the strobe), a good block is loaded only if its offset is A or C'. Other blocks leave the last register, the previous register, dav and ovf unchanged.
- R5: When fast_pi=0 or sync=1, every good block is loaded. A bad block is never loaded.
- R6: Loading a block copies the old last value into the previous register, puts the new word into the last register, and sets dav=1 with dav_n=0.
- R7: If a block is loaded while dav is already 1, ovf is set to 1.
- R8: A read of the last register (rd_en=1, rd_sel=1) clears dav and ovf. A block strobed in that same cycle is dropped and is not loaded.
- R9: irq is set when a block is loaded or when sync is established. A flag read (rd_en=1, rd_sel=0) clears irq unless irq is set again in that same cycle. A flag read leaves dav and ovf unchanged.
- R10: rd_data shows the selected register. With rd_sel=0 it shows the flags: bit0 dav, bit1 ovf, bit2 sync, bit3 irq, other bits 0. With rd_sel=1 it shows the last register, with rd_sel=2 the previous register, and with rd_sel=3 it is 0.
- R11: If the host does one extra read of the last register after clearing ovf and before the next block, the next load leaves ovf at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_pi | input | 1 | 1 selects fast PI-search mode |
| blk_stb | input | 1 | One-cycle strobe for a completed block |
| blk_ofs | input | 3 | Offset type of the strobed block |
| blk_good | input | 1 | Strobed block passed its check |
| blk_data | input | 16 | Data word of the strobed block |
| rd_en | input | 1 | Host access strobe |
| rd_sel | input | 2 | Host register select |
| rd_data | output | 16 | Selected register contents |
| dav | output | 1 | Data-available flag |
| dav_n | output | 1 | Active-low copy of dav |
| ovf | output | 1 | Overflow flag: two unread blocks are held |
| sync | output | 1 | Block stream is in step |
| irq | output | 1 | Interrupt request |

## Verification
If the sequence tracker holds a wrong previous offset, sync rises one block too early or too late. In fast mode that also changes which offsets get loaded, so the error reaches dav and the last register at the next strobe. If the shift or flag logic is wrong, the previous register, ovf or irq are off in the cycle right after the strobe or read that caused it. The bench compares every output and the read mux on every cycle, so it reports such faults within one clock.

// File: rtl/rds_blkbuf_pkg.sv
package rds_blkbuf_pkg;
  typedef enum logic [2:0] {
    OFS_A  = 3'd0,
    OFS_B  = 3'd1,
    OFS_C  = 3'd2,
    OFS_CP = 3'd3,
    OFS_D  = 3'd4
  } ofs_e;

  localparam int OFS_W = 3;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_FLAGS = 2'd0;
  localparam logic [SEL_W-1:0] SEL_LAST  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_PREV  = 2'd2;

  function automatic logic ofs_valid(input logic [OFS_W-1:0] o);
    return o <= OFS_D;
  endfunction

  function automatic logic ofs_follows(input logic [OFS_W-1:0] p,
                                       input logic [OFS_W-1:0] c);
    logic r;
    case (p)
      OFS_A:         r = (c == OFS_B);
      OFS_B:         r = (c == OFS_C) || (c == OFS_CP);
      OFS_C, OFS_CP: r = (c == OFS_D);
      OFS_D:         r = (c == OFS_A);
      default:       r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic ofs_has_pi(input logic [OFS_W-1:0] o);
    return (o == OFS_A) || (o == OFS_CP);
  endfunction
endpackage

// File: rtl/rds_seq_sync.sv
module rds_seq_sync
  import rds_blkbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [OFS_W-1:0] ofs,
  input  logic             good,
  output logic             sync_q,
  output logic             sync_evt
);
  logic             pv_q;
  logic [OFS_W-1:0] po_q;
  logic             good_eff;

  assign good_eff = good && ofs_valid(ofs);
  assign sync_evt = stb && good_eff && !sync_q && pv_q && ofs_follows(po_q, ofs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q   <= 1'b0;
      po_q   <= '0;
      sync_q <= 1'b0;
    end else begin
      if (stb) begin
        pv_q <= good_eff;
        if (good_eff) po_q <= ofs;
      end
      if (sync_evt) sync_q <= 1'b1;
    end
  end

  assert_sync_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> sync_q);
  assert_sync_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sync_q));
endmodule

// File: rtl/rds_blk_regs.sv
module rds_blk_regs
  import rds_blkbuf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [OFS_W-1:0] ofs,
  input  logic             good,
  input  logic [DW-1:0]    data,
  input  logic             sync_q,
  input  logic             fast_pi,
  input  logic             rd_last,
  output logic [DW-1:0]    last_q,
  output logic [DW-1:0]    prev_q,
  output logic             dav_q,
  output logic             ovf_q,
  output logic             load
);
  logic pass_gate;

  assign pass_gate = sync_q || !fast_pi || ofs_has_pi(ofs);
  assign load      = stb && good && ofs_valid(ofs) && pass_gate && !rd_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      prev_q <= '0;
      dav_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (load) begin
        prev_q <= last_q;
        last_q <= data;
        dav_q  <= 1'b1;
        if (dav_q) ovf_q <= 1'b1;
      end else if (rd_last) begin
        dav_q <= 1'b0;
        ovf_q <= 1'b0;
      end
    end
  end

  assert_pi_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dav_q) && $past(fast_pi && !sync_q)) |-> $past(ofs_has_pi(ofs)));
  assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (prev_q == $past(last_q)));
  assert_ovf_has_dav_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> dav_q);
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> (!dav_q && !ovf_q));
endmodule

// File: rtl/rds_blkbuf.sv
module rds_blkbuf
  import rds_blkbuf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_pi,
  input  logic             blk_stb,
  input  logic [OFS_W-1:0] blk_ofs,
  input  logic             blk_good,
  input  logic [DW-1:0]    blk_data,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic             dav,
  output logic             dav_n,
  output logic             ovf,
  output logic             sync,
  output logic             irq
);
  localparam int FLAG_N = 4;

  logic          sync_evt, load, rd_last, rd_flags, irq_q;
  logic [DW-1:0] last_q, prev_q;

  assign rd_last  = rd_en && (rd_sel == SEL_LAST);
  assign rd_flags = rd_en && (rd_sel == SEL_FLAGS);

  rds_seq_sync u_sync (
    .clk(clk), .rst_n(rst_n), .stb(blk_stb), .ofs(blk_ofs), .good(blk_good),
    .sync_q(sync), .sync_evt(sync_evt)
  );

  rds_blk_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .stb(blk_stb), .ofs(blk_ofs), .good(blk_good),
    .data(blk_data), .sync_q(sync), .fast_pi(fast_pi), .rd_last(rd_last),
    .last_q(last_q), .prev_q(prev_q), .dav_q(dav), .ovf_q(ovf), .load(load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq_q <= 1'b0;
    else if (sync_evt || load) irq_q <= 1'b1;
    else if (rd_flags)         irq_q <= 1'b0;
  end

  assign irq   = irq_q;
  assign dav_n = !dav;

  always_comb begin
    case (rd_sel)
      SEL_FLAGS: rd_data = {{(DW-FLAG_N){1'b0}}, irq_q, sync, ovf, dav};
      SEL_LAST:  rd_data = last_q;
      SEL_PREV:  rd_data = prev_q;
      default:   rd_data = '0;
    endcase
  end

  assert_irq_on_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> irq);
  assert_irq_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> irq);
  assert_flagread_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !blk_stb) |=> ($stable(dav) && $stable(ovf)));
endmodule

// File: tb/rds_blkbuf_test.sv
module rds_blkbuf_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, fast_pi = 1'b0;
  logic        blk_stb = 1'b0, blk_good = 1'b0, rd_en = 1'b0;
  logic [2:0]  blk_ofs = '0;
  logic [15:0] blk_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        dav, dav_n, ovf, sync, irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rds_blkbuf uut (
    .clk(clk), .rst_n(rst_n), .fast_pi(fast_pi), .blk_stb(blk_stb),
    .blk_ofs(blk_ofs), .blk_good(blk_good), .blk_data(blk_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .dav(dav),
    .dav_n(dav_n), .ovf(ovf), .sync(sync), .irq(irq)
  );

  // reference state
  logic        m_sync, m_pv, m_dav, m_ovf, m_irq;
  logic [2:0]  m_po;
  logic [15:0] m_last, m_prev;

  function automatic bit succ_ok(input logic [2:0] p, input logic [2:0] c);
    if (p == 3'd0) return c == 3'd1;
    if (p == 3'd1) return c == 3'd2 || c == 3'd3;
    if (p == 3'd2 || p == 3'd3) return c == 3'd4;
    if (p == 3'd4) return c == 3'd0;
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [1:0] s);
    if (s == 2'd0) return {12'd0, m_irq, m_sync, m_ovf, m_dav};
    if (s == 2'd1) return m_last;
    if (s == 2'd2) return m_prev;
    return 16'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R6 dav", dav, m_dav);
    chk("R6 dav_n", dav_n, !m_dav);
    chk("R7 ovf", ovf, m_ovf);
    chk("R3 sync", sync, m_sync);
    chk("R9 irq", irq, m_irq);
    chk("R10 rd_data", rd_data, exp_rd(rd_sel));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; blk_stb = 0; rd_en = 0; rd_sel = 2'd0;
    m_sync = 0; m_pv = 0; m_po = 0; m_dav = 0; m_ovf = 0; m_irq = 0;
    m_last = 0; m_prev = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk("R1 dav", dav, 1'b0); chk("R1 dav_n", dav_n, 1'b1);
    chk("R1 ovf", ovf, 1'b0); chk("R1 sync", sync, 1'b0);
    chk("R1 irq", irq, 1'b0); chk("R1 flags", rd_data, 16'd0);
    rd_sel = 2'd1; #1 chk("R1 last", rd_data, 16'd0);
    rd_sel = 2'd2; #1 chk("R1 prev", rd_data, 16'd0);
  endtask

  // called at a negedge; drives inputs, advances model, checks after the edge
  task automatic step(input bit s, input logic [2:0] o, input bit g,
                      input logic [15:0] d, input bit r, input logic [1:0] sel);
    bit good_v, evt, take, rl, rf;
    blk_stb = s; blk_ofs = o; blk_good = g; blk_data = d; rd_en = r; rd_sel = sel;
    good_v = g && (o < 3'd5);
    rl = r && sel == 2'd1;
    rf = r && sel == 2'd0;
    evt  = s && good_v && !m_sync && m_pv && succ_ok(m_po, o);
    take = s && good_v && !rl && (m_sync || !fast_pi || o == 3'd0 || o == 3'd3);
    @(posedge clk);
    if (s) begin m_pv = good_v; if (good_v) m_po = o; end
    if (take) begin
      m_prev = m_last; m_last = d;
      if (m_dav) m_ovf = 1'b1;
      m_dav = 1'b1;
    end else if (rl) begin
      m_dav = 1'b0; m_ovf = 1'b0;
    end
    if (evt || take) m_irq = 1'b1; else if (rf) m_irq = 1'b0;
    if (evt) m_sync = 1'b1;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] seq;
    void'($urandom(32'h5eed_1234));
    // directed: fast PI-search mode
    fast_pi = 1'b1;
    do_reset();
    step(1, 3'd1, 1, 16'h1111, 0, 2'd1); chk("R4 B ignored", dav, 1'b0);
    step(1, 3'd0, 1, 16'h2222, 0, 2'd1); chk("R4 A loaded", rd_data, 16'h2222);
    chk("R2 no sync on B->A", sync, 1'b0);
    step(1, 3'd1, 1, 16'h3333, 0, 2'd1); chk("R2 sync on A->B", sync, 1'b1);
    chk("R3 irq on sync", irq, 1'b1); chk("R4 B not loaded", rd_data, 16'h2222);
    step(1, 3'd2, 1, 16'h4444, 0, 2'd2); chk("R6 prev", rd_data, 16'h2222);
    chk("R7 ovf set", ovf, 1'b1);
    step(0, 3'd0, 0, 16'h0, 1, 2'd0); chk("R9 irq cleared", irq, 1'b0);
    chk("R9 dav kept", dav, 1'b1); chk("R9 ovf kept", ovf, 1'b1);
    step(1, 3'd4, 1, 16'h5555, 1, 2'd1); chk("R8 dropped", rd_data, 16'h4444);
    chk("R8 dav cleared", dav, 1'b0); chk("R8 ovf cleared", ovf, 1'b0);
    step(1, 3'd0, 0, 16'h6666, 0, 2'd1); chk("R5 bad ignored", dav, 1'b0);
    step(1, 3'd0, 1, 16'h7777, 0, 2'd1); chk("R11 no ovf", ovf, 1'b0);
    step(1, 3'd1, 1, 16'h7878, 0, 2'd3); chk("R10 sel3 zero", rd_data, 16'h0);
    // directed: normal mode loads any good block
    fast_pi = 1'b0;
    do_reset();
    step(1, 3'd4, 1, 16'h9999, 0, 2'd1); chk("R5 D loaded", rd_data, 16'h9999);
    step(1, 3'd6, 1, 16'haaaa, 0, 2'd1); chk("R2 code6 bad", rd_data, 16'h9999);
    step(1, 3'd0, 1, 16'hbbbb, 0, 2'd0); chk("R2 bad breaks pair", sync, 1'b0);
    // random episodes
    for (int ep = 0; ep < 8; ep++) begin
      fast_pi = ep[0];
      do_reset();
      seq = 3'd0;
      for (int i = 0; i < 2000; i++) begin
        bit s, g, r;
        logic [2:0] o;
        s = ($urandom % 5) == 0;
        g = ($urandom % 8) != 0;
        r = ($urandom % 4) == 0;
        o = (($urandom % 4) == 0) ? 3'($urandom % 6) : seq;
        if (s) seq = (o == 3'd0) ? 3'd1 : (o == 3'd1) ? (($urandom % 2) ? 3'd2 : 3'd3)
                   : (o == 3'd4) ? 3'd0 : 3'd4;
        step(s, o, g, 16'($urandom), r, 2'($urandom % 4));
      end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule